// File: doc/BRIEF.md
# DAC Conversion Sequencer

This block decides when a 12-bit digital-to-analog converter receives a new code. The converter has a direct output and two sample-and-hold channels, A and B. Each channel has its own data holding register, enable and trigger mode. In software mode a write to a channel's data register requests a conversion. In event mode the channel fetches its next word through a DMA request/acknowledge handshake and converts it only when a trigger event arrives. Every conversion is issued to the analog core as a one-cycle strobe, together with the channel select and the data word. All outputs are registered.

The sequencer keeps consecutive conversions at least one sampling interval apart. That interval grows by half when sample-and-hold is in use. Requests that arrive early are held until the interval allows them. When both channels wait at the same time they take turns. A programmable startup wait follows each enable. An optional refresh timer re-issues the last channel's word when the output would otherwise go stale. Routing the converter output internally turns sample-and-hold off, and channel A then drives the direct output alone.

Top module: `dac_conv_seq`

## Requirements
- R1: While `en` is low, all pending requests, the stored words, the interval, refresh and startup counters, `dma_req` and `overrun` are cleared, and no strobe is issued. A request made before a disable never converts after re-enable.
- R2: After `en` is first sampled high at a clock edge E, no strobe occurs before edge E+S+1, where S = `startup_len`. A software write sampled together with that first enable converts exactly at edge E+S+1.
- R3: Let Pc = max(`samp_period`, MIN_PERIOD). The interval T is Pc without sample-and-hold and Pc + floor(Pc/2) with it. Two strobes are never closer than T edges. A request that is pending when T expires issues exactly T edges after the previous strobe.
- R4: Sample-and-hold is active only when `sh_mode`=1 and `int_route`=0. Otherwise channel B (select 1) ignores writes and events, and T uses the direct formula.
- R5: On a software-mode channel, a write sampled at edge k stores `wr_word` and, if the interval allows it, produces a one-cycle `conv_stb` at edge k+1. The strobe carries `conv_sel` (0 = A, 1 = B) and `conv_word` equal to the written word.
- R6: On an event-mode channel, `dma_req` rises one edge after startup completes while no word is staged. An acknowledge sampled with the request high latches `dma_word` and drops the request at that same edge. The staged word converts only after the next `trig_evt`, with the strobe one edge after the event is sampled. The request then rises again.
- R7: When both channels are pending, they are served alternately, and channel A is first after enable. When only one channel is pending, that channel is served, and the turn then passes to the other channel.
- R8: A new request on a channel that already has one pending, and is not being served in that cycle, sets the sticky `overrun` output. The newest word is the one converted.
- R9: With `refr_en`=1 and no request pending, the last converted channel's word is issued again R edges after the previous strobe, with R = max(`refr_period`, T). This repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low clears all state |
| sh_mode | input | 1 | Request sample-and-hold operation |
| int_route | input | 1 | Output routed internally; forces sample-and-hold off |
| ch_en | input | 2 | Per-channel enable (bit 0 = A, bit 1 = B) |
| auto_trig | input | 2 | Per-channel event mode with DMA fetch |
| refr_en | input | 1 | Enable automatic refresh |
| startup_len | input | SW | Startup wait in cycles |
| samp_period | input | PW | Programmed sampling period in cycles |
| refr_period | input | PW+1 | Refresh interval in cycles |
| wr_strobe | input | 2 | Per-channel data register write |
| wr_word | input | DW | Write data |
| trig_evt | input | 1 | Trigger event pulse |
| dma_req | output | 2 | Per-channel DMA request |
| dma_ack | input | 2 | Per-channel DMA acknowledge |
| dma_word | input | DW | Data delivered with acknowledge |
| conv_stb | output | 1 | One-cycle convert strobe |
| conv_sel | output | 1 | Channel of the conversion |
| conv_word | output | DW | Code to convert |
| overrun | output | 1 | Sticky request overrun |

## Verification
The interval is swept over every programmed period, both with and without sample-and-hold, and with internal routing on and off. This separates the clamp, the half-period stretch and the routing override. The startup wait is swept over several lengths. The refresh interval is tried below, at and above T, which separates the clamp from the normal refresh repetition. Simultaneous writes to both channels, and a re-write of A while B still waits, distinguish round-robin from fixed priority. Single and double writes inside one interval show where the overrun flag starts. The DMA sequence shows that an acknowledged word waits for an event.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  localparam int NCH = 2;
  localparam logic SEL_A = 1'b0;
  localparam logic SEL_B = 1'b1;
  typedef logic [NCH-1:0] chvec_t;
endpackage

// File: rtl/dac_seq_startup.sv
module dac_seq_startup #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [SW-1:0] len,
  output logic          started
);
  localparam logic [SW-1:0] ONE = SW'(1);
  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt     <= '0;
      started <= 1'b0;
    end else if (!started) begin
      if (cnt == len) started <= 1'b1;
      else            cnt     <= cnt + ONE;
    end
  end

  // R1: disabling drops the started state
  p_start_drop_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> !started);
endmodule

// File: rtl/dac_seq_chan.sv
module dac_seq_chan #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          active,
  input  logic          auto_mode,
  input  logic          started,
  input  logic          wr,
  input  logic [DW-1:0] wr_word,
  input  logic          ack,
  input  logic [DW-1:0] dma_word,
  input  logic          evt,
  input  logic          grant,
  output logic          pending,
  output logic [DW-1:0] data,
  output logic          req,
  output logic          trig_ovr
);
  logic [DW-1:0] stage;
  logic          full;
  logic          load, take, trig, full_n;

  always_comb begin
    load     = auto_mode & (wr | (ack & req));
    take     = auto_mode & evt & full;
    trig     = auto_mode ? take : wr;
    full_n   = load | (full & ~take);
    trig_ovr = trig & pending & ~grant;
  end

  always_ff @(posedge clk) begin
    if (rst || !en || !active) begin
      stage   <= '0;
      full    <= 1'b0;
      data    <= '0;
      pending <= 1'b0;
      req     <= 1'b0;
    end else begin
      if (load) stage <= wr ? wr_word : dma_word;
      full <= full_n;
      if (take)                 data <= stage;
      else if (!auto_mode && wr) data <= wr_word;
      pending <= trig | (pending & ~grant);
      req     <= auto_mode & started & ~full_n;
    end
  end

  // R6: an accepted acknowledge withdraws the request
  p_req_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> !req);
  // R8: a pending request survives until it is served
  p_pend_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (pending && !grant && en && active) |=> pending);
endmodule

// File: rtl/dac_seq_arb.sv
module dac_seq_arb
  import dac_seq_pkg::*;
#(
  parameter int DW         = 12,
  parameter int PW         = 4,
  parameter int MIN_PERIOD = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    started,
  input  logic                    sh_act,
  input  logic                    refr_en,
  input  chvec_t                  active,
  input  chvec_t                  pending,
  input  logic [NCH-1:0][DW-1:0]  data,
  input  logic [PW-1:0]           samp_period,
  input  logic [PW:0]             refr_period,
  output chvec_t                  grant,
  output logic                    conv_stb,
  output logic                    conv_sel,
  output logic [DW-1:0]           conv_word
);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] MINP = CW'(MIN_PERIOD);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] per_c, t_int, r_int, gap, rcnt;
  logic          rr, last_ch, have_last;
  logic          ready, issue, from_pend, sel;

  always_comb begin
    per_c     = ({1'b0, samp_period} < MINP) ? MINP : {1'b0, samp_period};
    t_int     = sh_act ? per_c + (per_c >> 1) : per_c;
    r_int     = (refr_period < t_int) ? t_int : refr_period;
    ready     = started && (gap >= t_int - ONE);
    issue     = 1'b0;
    from_pend = 1'b0;
    sel       = SEL_A;
    if (ready) begin
      if (&pending) begin
        sel = rr; issue = 1'b1; from_pend = 1'b1;
      end else if (|pending) begin
        sel = pending[1]; issue = 1'b1; from_pend = 1'b1;
      end else if (refr_en && have_last && active[last_ch] &&
                   (rcnt >= r_int - ONE)) begin
        sel = last_ch; issue = 1'b1;
      end
    end
    grant = from_pend ? (chvec_t'(1) << sel) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      gap       <= '1;
      rcnt      <= '0;
      rr        <= SEL_A;
      last_ch   <= SEL_A;
      have_last <= 1'b0;
      conv_stb  <= 1'b0;
      conv_sel  <= SEL_A;
      conv_word <= '0;
    end else begin
      conv_stb <= issue;
      if (issue) begin
        conv_sel  <= sel;
        conv_word <= data[sel];
        gap       <= '0;
        rcnt      <= '0;
        last_ch   <= sel;
        have_last <= 1'b1;
        if (from_pend) rr <= ~sel;
      end else begin
        if (gap < t_int - ONE)  gap  <= gap + ONE;
        if (rcnt < r_int - ONE) rcnt <= rcnt + ONE;
      end
    end
  end

  // checker counter: edges since the previous strobe
  logic [CW:0] chk_since;
  always_ff @(posedge clk) begin
    if (rst || !en)          chk_since <= '1;
    else if (conv_stb)       chk_since <= (CW+1)'(1);
    else if (chk_since != '1) chk_since <= chk_since + (CW+1)'(1);
  end

  // R3: strobes never closer than the effective interval
  p_min_gap_r3: assert property (@(posedge clk) disable iff (rst)
    conv_stb |-> (chk_since >= {1'b0, t_int}));
  // R7: at most one channel served per cycle
  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: rtl/dac_conv_seq.sv
module dac_conv_seq
  import dac_seq_pkg::*;
#(
  parameter int DW         = 12,
  parameter int PW         = 4,
  parameter int SW         = 4,
  parameter int MIN_PERIOD = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          sh_mode,
  input  logic          int_route,
  input  logic [1:0]    ch_en,
  input  logic [1:0]    auto_trig,
  input  logic          refr_en,
  input  logic [SW-1:0] startup_len,
  input  logic [PW-1:0] samp_period,
  input  logic [PW:0]   refr_period,
  input  logic [1:0]    wr_strobe,
  input  logic [DW-1:0] wr_word,
  input  logic          trig_evt,
  output logic [1:0]    dma_req,
  input  logic [1:0]    dma_ack,
  input  logic [DW-1:0] dma_word,
  output logic          conv_stb,
  output logic          conv_sel,
  output logic [DW-1:0] conv_word,
  output logic          overrun
);
  logic                   started, sh_act;
  chvec_t                 act, pend, grant, ovr, req;
  logic [NCH-1:0][DW-1:0] ch_data;

  always_comb begin
    sh_act = sh_mode & ~int_route;
    act[0] = ch_en[0];
    act[1] = ch_en[1] & sh_act;
  end

  dac_seq_startup #(.SW(SW)) u_start (
    .clk(clk), .rst(rst), .en(en), .len(startup_len), .started(started)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dac_seq_chan #(.DW(DW)) u_ch (
      .clk(clk), .rst(rst), .en(en), .active(act[g]),
      .auto_mode(auto_trig[g]), .started(started),
      .wr(wr_strobe[g]), .wr_word(wr_word),
      .ack(dma_ack[g]), .dma_word(dma_word), .evt(trig_evt),
      .grant(grant[g]), .pending(pend[g]), .data(ch_data[g]),
      .req(req[g]), .trig_ovr(ovr[g])
    );
  end

  assign dma_req = req;

  dac_seq_arb #(.DW(DW), .PW(PW), .MIN_PERIOD(MIN_PERIOD)) u_arb (
    .clk(clk), .rst(rst), .en(en), .started(started), .sh_act(sh_act),
    .refr_en(refr_en), .active(act), .pending(pend), .data(ch_data),
    .samp_period(samp_period), .refr_period(refr_period), .grant(grant),
    .conv_stb(conv_stb), .conv_sel(conv_sel), .conv_word(conv_word)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) overrun <= 1'b0;
    else if (|ovr)  overrun <= 1'b1;
  end

  // R2: no strobe until the startup wait has completed
  p_wait_startup_r2: assert property (@(posedge clk) disable iff (rst)
    conv_stb |-> $past(started));
  // R1: disabled block stays quiet
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!conv_stb && dma_req == 2'b00 && !overrun));
  // R8: overrun holds while enabled
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (overrun && en) |=> overrun);
  // R4: channel B converts only with sample-and-hold active
  p_b_needs_sh_r4: assert property (@(posedge clk) disable iff (rst)
    (conv_stb && conv_sel) |-> $past(act[1]));
endmodule

// File: tb/sim_dac_conv_seq.sv
module sim_dac_conv_seq;
  localparam int CLK_NS = 10;
  localparam int DW = 12, PW = 4, SW = 4, MINP = 2;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, sh_mode = 1'b0, int_route = 1'b0;
  logic [1:0] ch_en = 2'b01, auto_trig = 2'b00, wr_strobe = 2'b00, dma_ack = 2'b00;
  logic refr_en = 1'b0, trig_evt = 1'b0;
  logic [SW-1:0] startup_len = '0;
  logic [PW-1:0] samp_period = '0;
  logic [PW:0]   refr_period = '0;
  logic [DW-1:0] wr_word = '0, dma_word = '0;
  logic [1:0] dma_req;
  logic conv_stb, conv_sel, overrun;
  logic [DW-1:0] conv_word;
  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  dac_conv_seq #(.DW(DW), .PW(PW), .SW(SW), .MIN_PERIOD(MINP)) u0 (
    .clk(clk), .rst(rst), .en(en), .sh_mode(sh_mode), .int_route(int_route),
    .ch_en(ch_en), .auto_trig(auto_trig), .refr_en(refr_en),
    .startup_len(startup_len), .samp_period(samp_period),
    .refr_period(refr_period), .wr_strobe(wr_strobe), .wr_word(wr_word),
    .trig_evt(trig_evt), .dma_req(dma_req), .dma_ack(dma_ack),
    .dma_word(dma_word), .conv_stb(conv_stb), .conv_sel(conv_sel),
    .conv_word(conv_word), .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_stb(input int lim, output int n);
    int k;
    n = -1; k = 0;
    while (k < lim && n < 0) begin
      @(negedge clk); k++;
      wr_strobe = '0; trig_evt = 1'b0; dma_ack = '0;
      if (conv_stb) n = k;
    end
  endtask

  task automatic go_off();
    en = 1'b0; tick(); tick();
  endtask

  function automatic int t_exp(input int p, input bit sh, input bit ir);
    int pc;
    pc = (p < MINP) ? MINP : p;
    return (sh && !ir) ? pc + pc / 2 : pc;
  endfunction

  initial begin
    int n;
    repeat (4) tick();
    rst = 1'b0; tick();
    chk("R1 reset stb", conv_stb, 0);
    chk("R1 reset req", dma_req, 0);
    chk("R1 reset ovr", overrun, 0);

    // startup sweep
    samp_period = 4'd2;
    for (int s = 0; s < 6; s++) begin
      go_off();
      startup_len = SW'(s);
      en = 1'b1; wr_strobe = 2'b01; wr_word = DW'(s * 100 + 7);
      wait_stb(40, n);
      chk("R2 startup edge", n, s + 2);
      chk("R5 word", conv_word, s * 100 + 7);
      chk("R5 sel", conv_sel, 0);
      tick();
      chk("R5 single cycle", conv_stb, 0);
    end

    // interval sweep
    startup_len = '0; ch_en = 2'b11;
    for (int sh = 0; sh < 2; sh++)
      for (int ir = 0; ir < 2; ir++)
        for (int p = 0; p < 16; p++) begin
          go_off();
          sh_mode = sh[0]; int_route = ir[0]; samp_period = PW'(p);
          en = 1'b1; wr_strobe = 2'b01; wr_word = 12'h111;
          wait_stb(60, n);
          wr_strobe = 2'b01; wr_word = 12'h222;
          wait_stb(60, n);
          chk(ir ? "R4 interval routed" : "R3 interval", n, t_exp(p, sh[0], ir[0]));
          chk("R3 word", conv_word, 12'h222);
        end

    // channel B ignored without sample-and-hold
    for (int m = 0; m < 2; m++) begin
      go_off();
      sh_mode = (m == 0); int_route = (m == 0); samp_period = 4'd2;
      en = 1'b1; wr_strobe = 2'b10; wr_word = 12'h0B0;
      wait_stb(20, n);
      chk("R4 B ignored", n, -1);
      wr_strobe = 2'b01; wr_word = 12'h0A0;
      wait_stb(20, n);
      chk("R4 A still converts", conv_sel, 0);
    end
    go_off();
    sh_mode = 1'b1; int_route = 1'b0;
    en = 1'b1; wr_strobe = 2'b10; wr_word = 12'h5B5;
    wait_stb(20, n);
    chk("R5 B edge", n, 2);
    chk("R5 B sel", conv_sel, 1);
    chk("R5 B word", conv_word, 12'h5B5);

    // round robin, T = 3
    go_off();
    en = 1'b1; wr_strobe = 2'b11; wr_word = 12'h321;
    wait_stb(20, n); chk("R7 first A", conv_sel, 0);
    wait_stb(20, n); chk("R7 then B", conv_sel, 1); chk("R7 gap", n, 3);
    wr_strobe = 2'b10; wait_stb(20, n); chk("R7 lone B", conv_sel, 1);
    tick(); tick(); tick();
    wr_strobe = 2'b11; wait_stb(20, n); chk("R7 A after B", conv_sel, 0);
    wr_strobe = 2'b01; wait_stb(20, n); chk("R7 B before rewritten A", conv_sel, 1);
    wait_stb(20, n); chk("R7 A last", conv_sel, 0);

    // overrun, direct mode, T = 15
    go_off();
    sh_mode = 1'b0; samp_period = 4'd15;
    en = 1'b1; wr_strobe = 2'b01; wr_word = 12'h001;
    wait_stb(20, n);
    wr_strobe = 2'b01; wr_word = 12'h002; tick(); wr_strobe = '0; tick();
    chk("R8 single pending no ovr", overrun, 0);
    wr_strobe = 2'b01; wr_word = 12'h003; tick(); wr_strobe = '0; tick();
    chk("R8 ovr set", overrun, 1);
    wait_stb(30, n);
    chk("R8 newest word", conv_word, 12'h003);
    chk("R8 sticky", overrun, 1);
    go_off();
    chk("R1 ovr cleared", overrun, 0);

    // disable clears pending
    en = 1'b1; wr_strobe = 2'b01; wr_word = 12'h044;
    wait_stb(20, n);
    wr_strobe = 2'b01; tick(); wr_strobe = '0;
    go_off();
    wait_stb(20, n); chk("R1 off no stb", n, -1);
    en = 1'b1;
    wait_stb(25, n); chk("R1 pending dropped", n, -1);

    // DMA event mode
    go_off();
    samp_period = 4'd2; auto_trig = 2'b01; ch_en = 2'b01; startup_len = 4'd2;
    en = 1'b1;
    tick(); chk("R6 no req in startup", dma_req, 0);
    tick(); tick(); chk("R6 no req yet", dma_req, 0);
    tick(); chk("R6 req up", dma_req, 1);
    dma_ack = 2'b01; dma_word = 12'hABC;
    tick(); dma_ack = '0;
    chk("R6 req dropped", dma_req, 0);
    wait_stb(6, n); chk("R6 waits for event", n, -1);
    trig_evt = 1'b1;
    wait_stb(10, n);
    chk("R6 event edge", n, 2);
    chk("R6 word", conv_word, 12'hABC);
    chk("R6 req again", dma_req, 1);

    // refresh, T = 4
    auto_trig = 2'b00; startup_len = '0;
    for (int i = 0; i < 5; i++) begin
      int rv;
      rv = (i == 0) ? 0 : (i == 1) ? 3 : (i == 2) ? 4 : (i == 3) ? 7 : 11;
      go_off();
      samp_period = 4'd4; refr_en = 1'b1; refr_period = (PW+1)'(rv);
      en = 1'b1; wr_strobe = 2'b01; wr_word = 12'h7E7;
      wait_stb(20, n);
      wait_stb(40, n);
      chk("R9 refresh gap", n, (rv < 4) ? 4 : rv);
      chk("R9 refresh word", conv_word, 12'h7E7);
      wait_stb(40, n);
      chk("R9 repeats", n, (rv < 4) ? 4 : rv);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule